// File: doc/BRIEF.md
# EPROM Program-Verify Sequencer

This block writes a contiguous range of words into an external UV or one-time-programmable EPROM by driving its pins directly. Software or a host state machine gives it a first and a last address and a start strike. For every word it takes a data word from a streaming source. It then raises the programming supply and applies a timed program strobe, and reads the word back to verify it. It repeats the strobe until the read-back matches or until it has applied the maximum number of strobes.

Once the last word passes, the sequencer re-reads the whole range twice with no strobes. The first pass uses the upper check supply level and the second uses the lower one. The host voltage regulator follows a two-bit supply-select output; the block never regulates a supply itself. The data source must present the same word sequence again for each check pass. The block ends with a pass or a fail flag. On a fail it also reports the failing address and the number of strobes that word received.

All pin timing is counted in clock cycles, derived from the parameter `CLK_HZ` and from parameters given in microseconds. The strobe width is rejected at elaboration if it lies outside 95 to 105 us.

Top module: `eprom_pv_seq`

## Requirements
- R1: After reset and whenever idle, chip enable, output enable and program strobe are high (inactive), the data bus is released, supply select is 0 (read level), `busy_o` and `src_ready_o` are low.
- R2: The program strobe goes low only while chip enable is low and supply select is 1 (programming level: 6.25 V supply, 12.75 V programming supply).
- R3: Address, write data, data-bus drive, chip enable and supply select are unchanged for at least `SETUP_US` before every strobe falls, and the data bus is driven throughout the strobe.
- R4: Every strobe is low for exactly `PULSE_US` x `CLK_HZ`/1e6 cycles. A `PULSE_US` outside 95..105 is an elaboration error.
- R5: After a strobe rises, the data bus stays driven for at least `HOLD_US`. Output enable does not fall earlier than `HOLD_US` + `OE_SETUP_US` after the rise. Output enable and data-bus drive are never active together.
- R6: Each word gets a strobe followed by a verify read, repeated until the read equals the word. A word that needs k strobes, with k no greater than `RETRY_MAX` (25), receives exactly k, with no extra strobe.
- R7: If the verify after the `RETRY_MAX`-th strobe still mismatches, the run ends with `fail_o`=1, `fail_addr_o` = that word and `fail_pulses_o` = `RETRY_MAX`. No later word receives a strobe and no check pass starts.
- R8: After the last word passes, every word from first to last is read once with supply select 2 (6 V check), then once more with supply select 3 (4.2 V check), with no strobe in either pass.
- R9: A mismatch in either check pass ends the run with `fail_o`=1, `fail_addr_o` = that word and `fail_pulses_o` = 0. A mismatch in the supply-2 pass means no supply-3 read occurs.
- R10: `src_ready_o` is high for exactly one accepted word per address per pass. A passing run over N words accepts 3N words.
- R11: `start_i` is ignored while `busy_o` is high. `pass_o`, `fail_o`, `fail_addr_o` and `fail_pulses_o` hold until the next accepted start. At the end of a run, supply select returns to 0 and chip enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strike, sampled when idle |
| first_addr_i | input | ADDR_W | First word address of the range |
| last_addr_i | input | ADDR_W | Last word address of the range |
| src_valid_i | input | 1 | Source word valid |
| src_data_i | input | DATA_W | Source word for the current address |
| src_ready_o | output | 1 | Sequencer accepts a source word |
| mem_addr_o | output | ADDR_W | Memory address pins |
| mem_wdata_o | output | DATA_W | Data driven to the memory data pins |
| mem_wdata_oe_o | output | 1 | Drive enable for the data pins |
| mem_rdata_i | input | DATA_W | Data read from the memory data pins |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_pgm_n_o | output | 1 | Program strobe, active low |
| supply_sel_o | output | 2 | 0 read, 1 program, 2 upper check, 3 lower check |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run passed |
| fail_o | output | 1 | Last run failed |
| fail_addr_o | output | ADDR_W | Address of the failing word |
| fail_pulses_o | output | $clog2(RETRY_MAX+1) | Strobes applied to the failing word, 0 for a check failure |

## Verification
The bench attaches a behavioural memory in which each cell needs a chosen number of strobes to take its data. It also has chosen cells that read wrong at one check supply. The runs cover words needing exactly 25 strobes, which must pass, and exactly 26, which must fail with nothing programmed beyond that word. A design with an off-by-one retry cap would either fail the first case or program a 26th time. A sequencer that added an overprogram strobe would show up in the per-cell strobe counts. One that skipped or reordered the check passes would show wrong read counts per supply level. A weak cell at the upper check level must stop the run before any lower-level read. Strobe width, setup, hold and output-enable gap are measured at the pins on every strobe. A start strike issued mid-run must leave the result and the strobe counts of the ignored range untouched.

// File: rtl/eprom_pv_pkg.sv
package eprom_pv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_OEGAP,
    ST_VERIFY,
    ST_CSETTLE,
    ST_CFETCH,
    ST_CREAD
  } pv_state_e;

  typedef enum logic [1:0] {
    SUP_READ   = 2'd0,
    SUP_PROG   = 2'd1,
    SUP_CHK_HI = 2'd2,
    SUP_CHK_LO = 2'd3
  } pv_supply_e;

endpackage

// File: rtl/eprom_pv_timer.sv
module eprom_pv_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R4: a loaded interval starts from exactly the loaded value
  assert_timer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/eprom_pv_tracker.sv
module eprom_pv_tracker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic              step_i,
  input  logic              rewind_i,
  input  logic              bump_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PCNT_W-1:0] pcnt_o,
  output logic              at_last_o
);

  logic [ADDR_W-1:0] first_q, last_q, addr_q, addr_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic              addr_en, pcnt_en;

  always_comb begin
    addr_en = load_i || rewind_i || step_i;
    if (load_i)        addr_d = first_i;
    else if (rewind_i) addr_d = first_q;
    else               addr_d = addr_q + 1'b1;
  end

  always_comb begin
    pcnt_en = load_i || rewind_i || step_i || bump_i;
    if (bump_i && !(load_i || rewind_i || step_i)) pcnt_d = pcnt_q + 1'b1;
    else                                            pcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (load_i) begin
      first_q <= first_i;
      last_q  <= last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  assign addr_o    = addr_q;
  assign pcnt_o    = pcnt_q;
  assign at_last_o = (addr_q == last_q);

  // R6: a passing word moves to the next address with a fresh strobe count
  assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !rewind_i) |=> (addr_q == $past(addr_q) + 1'b1) && (pcnt_q == '0));

  // R6: a mismatch adds exactly one to the strobe count
  assert_bump_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_i && !step_i && !load_i && !rewind_i) |=> (pcnt_q == $past(pcnt_q) + 1'b1));

endmodule

// File: rtl/eprom_pv_seq.sv
module eprom_pv_seq
  import eprom_pv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned PULSE_US    = 100,
  parameter int unsigned SETUP_US    = 2,
  parameter int unsigned HOLD_US     = 2,
  parameter int unsigned OE_SETUP_US = 2,
  parameter int unsigned READ_CYC    = 8,
  parameter int unsigned RETRY_MAX   = 25
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [ADDR_W-1:0]              first_addr_i,
  input  logic [ADDR_W-1:0]              last_addr_i,
  input  logic                           src_valid_i,
  input  logic [DATA_W-1:0]              src_data_i,
  output logic                           src_ready_o,
  output logic [ADDR_W-1:0]              mem_addr_o,
  output logic [DATA_W-1:0]              mem_wdata_o,
  output logic                           mem_wdata_oe_o,
  input  logic [DATA_W-1:0]              mem_rdata_i,
  output logic                           mem_ce_n_o,
  output logic                           mem_oe_n_o,
  output logic                           mem_pgm_n_o,
  output logic [1:0]                     supply_sel_o,
  output logic                           busy_o,
  output logic                           pass_o,
  output logic                           fail_o,
  output logic [ADDR_W-1:0]              fail_addr_o,
  output logic [$clog2(RETRY_MAX+1)-1:0] fail_pulses_o
);

  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned PULSE_CYC  = PULSE_US * CYC_PER_US;
  localparam int unsigned SETUP_CYC  = SETUP_US * CYC_PER_US;
  localparam int unsigned HOLD_CYC   = HOLD_US * CYC_PER_US;
  localparam int unsigned OE_CYC     = OE_SETUP_US * CYC_PER_US;
  localparam int unsigned PCNT_W     = $clog2(RETRY_MAX + 1);
  localparam int unsigned MAX_A      = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int unsigned MAX_B      = (HOLD_CYC > OE_CYC) ? HOLD_CYC : OE_CYC;
  localparam int unsigned MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC    = (MAX_C > READ_CYC) ? MAX_C : READ_CYC;
  localparam int unsigned TMR_W      = $clog2(MAX_CYC) + 1;

  localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] T_OE    = TMR_W'(OE_CYC - 1);
  localparam logic [TMR_W-1:0] T_READ  = TMR_W'(READ_CYC - 1);
  localparam logic [PCNT_W-1:0] P_LAST = PCNT_W'(RETRY_MAX - 1);
  localparam logic [PCNT_W-1:0] P_CAP  = PCNT_W'(RETRY_MAX);

  // Elaboration-time guards on the timing parameters
  if (PULSE_US < 95 || PULSE_US > 105) begin : g_bad_pulse
    $error("strobe width must lie within 95..105 us");
  end
  if (CLK_HZ % 1_000_000 != 0 || CLK_HZ == 0) begin : g_bad_clk
    $error("clock frequency must be a whole number of MHz");
  end
  if (SETUP_US == 0 || HOLD_US == 0 || OE_SETUP_US == 0 || READ_CYC == 0 || RETRY_MAX == 0) begin : g_bad_gap
    $error("every interval must be at least one unit");
  end

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pv_state_e         state_q, state_d;
  pv_supply_e        sup_q, sup_d;
  logic              chk_lo_q, chk_lo_d;
  logic [DATA_W-1:0] wdat_q;
  logic              wdat_en;

  logic              tmr_load, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic              trk_load, trk_step, trk_rewind, trk_bump, trk_last;
  logic [ADDR_W-1:0] trk_addr;
  logic [PCNT_W-1:0] trk_pcnt;

  logic              res_clr, res_pass, res_fail;
  logic [PCNT_W-1:0] res_pcnt;
  logic              pass_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [PCNT_W-1:0] fail_pcnt_q;
  logic              match;

  eprom_pv_timer #(.CNT_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  eprom_pv_tracker #(.ADDR_W(ADDR_W), .PCNT_W(PCNT_W)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (trk_load),
    .first_i  (first_addr_i),
    .last_i   (last_addr_i),
    .step_i   (trk_step),
    .rewind_i (trk_rewind),
    .bump_i   (trk_bump),
    .addr_o   (trk_addr),
    .pcnt_o   (trk_pcnt),
    .at_last_o(trk_last)
  );

  assign match = (mem_rdata_i == wdat_q);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    sup_d      = sup_q;
    chk_lo_d   = chk_lo_q;
    wdat_en    = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = T_SETUP;
    trk_load   = 1'b0;
    trk_step   = 1'b0;
    trk_rewind = 1'b0;
    trk_bump   = 1'b0;
    res_clr    = 1'b0;
    res_pass   = 1'b0;
    res_fail   = 1'b0;
    res_pcnt   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          trk_load = 1'b1;
          res_clr  = 1'b1;
          sup_d    = SUP_PROG;
          chk_lo_d = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
          state_d  = ST_SETTLE;
        end
      end
      ST_SETTLE: if (tmr_done) state_d = ST_FETCH;
      ST_FETCH: begin
        if (src_valid_i) begin
          wdat_en  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = T_PULSE;
          state_d  = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = T_HOLD;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = T_OE;
          state_d  = ST_OEGAP;
        end
      end
      ST_OEGAP: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          tmr_val  = T_READ;
          state_d  = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        if (tmr_done) begin
          if (match) begin
            if (trk_last) begin
              trk_rewind = 1'b1;
              sup_d      = SUP_CHK_HI;
              tmr_load   = 1'b1;
              tmr_val    = T_SETUP;
              state_d    = ST_CSETTLE;
            end else begin
              trk_step = 1'b1;
              state_d  = ST_FETCH;
            end
          end else if (trk_pcnt == P_LAST) begin
            res_fail = 1'b1;
            res_pcnt = P_CAP;
            sup_d    = SUP_READ;
            state_d  = ST_IDLE;
          end else begin
            trk_bump = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = T_SETUP;
            state_d  = ST_SETUP;
          end
        end
      end
      ST_CSETTLE: if (tmr_done) state_d = ST_CFETCH;
      ST_CFETCH: begin
        if (src_valid_i) begin
          wdat_en  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_READ;
          state_d  = ST_CREAD;
        end
      end
      ST_CREAD: begin
        if (tmr_done) begin
          if (!match) begin
            res_fail = 1'b1;
            sup_d    = SUP_READ;
            state_d  = ST_IDLE;
          end else if (!trk_last) begin
            trk_step = 1'b1;
            state_d  = ST_CFETCH;
          end else if (!chk_lo_q) begin
            chk_lo_d   = 1'b1;
            trk_rewind = 1'b1;
            sup_d      = SUP_CHK_LO;
            tmr_load   = 1'b1;
            tmr_val    = T_SETUP;
            state_d    = ST_CSETTLE;
          end else begin
            res_pass = 1'b1;
            sup_d    = SUP_READ;
            state_d  = ST_IDLE;
          end
        end
      end
      default: begin
        sup_d   = SUP_READ;
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      sup_q    <= SUP_READ;
      chk_lo_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sup_q    <= sup_d;
      chk_lo_q <= chk_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  wdat_q <= '0;
    else if (wdat_en) wdat_q <= src_data_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_pcnt_q <= '0;
    end else if (res_clr) begin
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      fail_pcnt_q <= '0;
    end else if (res_pass) begin
      pass_q <= 1'b1;
    end else if (res_fail) begin
      fail_q      <= 1'b1;
      fail_addr_q <= trk_addr;
      fail_pcnt_q <= res_pcnt;
    end
  end

  // Pin decode
  always_comb begin
    mem_ce_n_o     = 1'b1;
    mem_oe_n_o     = 1'b1;
    mem_pgm_n_o    = 1'b1;
    mem_wdata_oe_o = 1'b0;
    src_ready_o    = 1'b0;
    unique case (state_q)
      ST_SETUP, ST_HOLD: begin
        mem_ce_n_o     = 1'b0;
        mem_wdata_oe_o = 1'b1;
      end
      ST_PULSE: begin
        mem_ce_n_o     = 1'b0;
        mem_wdata_oe_o = 1'b1;
        mem_pgm_n_o    = 1'b0;
      end
      ST_OEGAP, ST_CFETCH: mem_ce_n_o = 1'b0;
      ST_VERIFY, ST_CREAD: begin
        mem_ce_n_o = 1'b0;
        mem_oe_n_o = 1'b0;
      end
      default: ;
    endcase
    if (state_q == ST_FETCH || state_q == ST_CFETCH) src_ready_o = 1'b1;
  end

  assign mem_addr_o    = trk_addr;
  assign mem_wdata_o   = wdat_q;
  assign supply_sel_o  = sup_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign pass_o        = pass_q;
  assign fail_o        = fail_q;
  assign fail_addr_o   = fail_addr_q;
  assign fail_pulses_o = fail_pcnt_q;

  // R2: strobe only with chip enabled at the programming supply
  assert_strobe_gated_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_pgm_n_o |-> (!mem_ce_n_o && supply_sel_o == SUP_PROG));

  // R3: data bus driven, output disabled, pins steady during the strobe
  assert_strobe_bus_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_pgm_n_o |-> (mem_wdata_oe_o && mem_oe_n_o));
  assert_strobe_steady_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_pgm_n_o && $past(!mem_pgm_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(supply_sel_o)));

  // R5: never drive the bus while the memory drives it
  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_wdata_oe_o && !mem_oe_n_o));

  // R7: the strobe count never passes the cap
  assert_retry_cap_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trk_pcnt < P_CAP);

  // R8: no strobe at either check level
  assert_check_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_sel_o == SUP_CHK_HI || supply_sel_o == SUP_CHK_LO) |-> mem_pgm_n_o);

  // R9: results are exclusive
  assert_result_excl_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(pass_o && fail_o));

  // R11: idle means deselected at the read supply, results held
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_o |-> (mem_ce_n_o && supply_sel_o == SUP_READ && !src_ready_o));
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(!busy_o) && !busy_o) |-> ($stable(pass_o) && $stable(fail_o) && $stable(fail_addr_o)));

endmodule

// File: tb/eprom_pv_seq_tb_top.sv
module eprom_pv_seq_tb_top;

  localparam int AW        = 4;
  localparam int DW        = 16;
  localparam int NW        = 1 << AW;
  localparam int CLK_HZ    = 2_000_000;
  localparam int CPU       = CLK_HZ / 1_000_000;
  localparam int PULSE_CYC = 100 * CPU;
  localparam int SETUP_CYC = 2 * CPU;
  localparam int HOLD_CYC  = 2 * CPU;
  localparam int OE_CYC    = 2 * CPU;
  localparam int RMAX      = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] first_i = '0, last_i = '0;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          wdata_oe, ce_n, oe_n, pgm_n;
  logic [1:0]    sup;
  logic          busy, pass_s, fail_s;
  logic [AW-1:0] fail_addr;
  logic [4:0]    fail_pulses;

  eprom_pv_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(CLK_HZ), .PULSE_US(100), .SETUP_US(2),
    .HOLD_US(2), .OE_SETUP_US(2), .READ_CYC(3), .RETRY_MAX(RMAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_addr_i(first_i), .last_addr_i(last_i),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_wdata_oe_o(wdata_oe), .mem_rdata_i(mem_rdata),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_pgm_n_o(pgm_n), .supply_sel_o(sup),
    .busy_o(busy), .pass_o(pass_s), .fail_o(fail_s), .fail_addr_o(fail_addr), .fail_pulses_o(fail_pulses)
  );

  // Behavioural memory and source
  logic [DW-1:0] cells [NW];
  int            pcount [NW];
  int            need [NW];
  int            weak_lo = -1, weak_hi = -1;
  logic [DW-1:0] seed = 16'h0;
  logic          model_clr = 1'b0;

  int n_chk = 0, n_fail = 0;
  int hs_cnt, reads_hi, reads_lo, reads_prog, gate_viol, setup_viol, width_viol, hold_viol;

  function automatic logic [DW-1:0] src_fn(input logic [AW-1:0] a, input logic [DW-1:0] s);
    int v;
    v = int'(a) * 40503 + 7;
    return DW'(v) ^ s ^ 16'h3C5A;
  endfunction

  assign src_valid = 1'b1;
  always_comb src_data = src_fn(mem_addr, seed);

  always_comb begin
    mem_rdata = '0;
    if (!ce_n && !oe_n) begin
      mem_rdata = cells[mem_addr];
      if (sup == 2'd3 && int'(mem_addr) == weak_lo) mem_rdata = mem_rdata ^ 16'h1;
      if (sup == 2'd2 && int'(mem_addr) == weak_hi) mem_rdata = mem_rdata ^ 16'h1;
    end
  end

  // Pin monitor, sampled mid-cycle
  logic [AW+DW+4:0] sig_prev;
  logic prev_pgm = 1'b1, prev_oe = 1'b1, tracking = 1'b0;
  int stab = 0, plen = 0, since = 0, hold = 0;

  always @(negedge clk) begin
    logic [AW+DW+4:0] sig;
    sig = {mem_addr, mem_wdata, wdata_oe, ce_n, sup};
    if (model_clr) begin
      for (int i = 0; i < NW; i++) begin
        cells[i] = '1;
        pcount[i] = 0;
      end
      hs_cnt = 0; reads_hi = 0; reads_lo = 0; reads_prog = 0;
      gate_viol = 0; setup_viol = 0; width_viol = 0; hold_viol = 0;
      tracking = 1'b0;
    end else begin
      if (sig != sig_prev) stab = 0; else stab++;
      if (prev_pgm && !pgm_n) begin
        if (stab < SETUP_CYC) setup_viol++;
        if (ce_n || sup != 2'd1 || !wdata_oe) gate_viol++;
        pcount[mem_addr]++;
        if (pcount[mem_addr] >= need[mem_addr]) cells[mem_addr] = cells[mem_addr] & mem_wdata;
        plen = 1;
      end else if (!pgm_n) begin
        plen++;
      end else if (!prev_pgm && pgm_n) begin
        if (plen != PULSE_CYC) width_viol++;
        tracking = 1'b1;
        since = 1;
        hold = wdata_oe ? 1 : 0;
      end else if (prev_oe && !oe_n) begin
        if (tracking && (hold < HOLD_CYC || since < HOLD_CYC + OE_CYC)) hold_viol++;
        tracking = 1'b0;
      end else if (tracking) begin
        since++;
        if (wdata_oe) hold++;
      end
      if (!oe_n && wdata_oe) hold_viol++;
      if (prev_oe && !oe_n) begin
        if (sup == 2'd1) reads_prog++;
        else if (sup == 2'd2) reads_hi++;
        else if (sup == 2'd3) reads_lo++;
      end
      if (src_ready && src_valid) hs_cnt++;
    end
    sig_prev = sig;
    prev_pgm = pgm_n;
    prev_oe = oe_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input int need_all, input logic [DW-1:0] s);
    for (int i = 0; i < NW; i++) need[i] = need_all;
    weak_lo = -1;
    weak_hi = -1;
    seed = s;
    @(posedge clk); model_clr = 1'b1;
    @(posedge clk); model_clr = 1'b0;
  endtask

  task automatic run(input int f, input int l);
    @(negedge clk);
    first_i = AW'(f); last_i = AW'(l); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic timing_checks(input string tag);
    check({"R2 strobe gating ", tag}, gate_viol, 0);
    check({"R3 setup before strobe ", tag}, setup_viol, 0);
    check({"R4 strobe width ", tag}, width_viol, 0);
    check({"R5 hold and output-enable gap ", tag}, hold_viol, 0);
  endtask

  logic wd_done = 1'b0;

  initial begin : watchdog
    repeat (195_000) @(posedge clk);
    if (!wd_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int tot;
    prep(1, 16'h0);
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ce_n in reset", ce_n, 1);
    check("R1 pgm_n in reset", pgm_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 ce_n idle", ce_n, 1);
    check("R1 oe_n idle", oe_n, 1);
    check("R1 pgm_n idle", pgm_n, 1);
    check("R1 bus released", wdata_oe, 0);
    check("R1 supply idle", sup, 0);
    check("R1 busy idle", busy, 0);
    check("R1 ready idle", src_ready, 0);

    // Full range, varied strobe needs
    prep(1, 16'h0);
    for (int i = 0; i < NW; i++) need[i] = (i % 4) + 1;
    run(0, NW - 1);
    check("R6 pass full range", pass_s, 1);
    check("R6 no fail full range", fail_s, 0);
    tot = 0;
    for (int i = 0; i < NW; i++) begin
      check($sformatf("R6 cell %0d content", i), cells[i], src_fn(AW'(i), 16'h0));
      check($sformatf("R6 strobes at %0d", i), pcount[i], (i % 4) + 1);
      tot += (i % 4) + 1;
    end
    check("R6 verify reads", reads_prog, tot);
    check("R8 upper check reads", reads_hi, NW);
    check("R8 lower check reads", reads_lo, NW);
    check("R10 source words", hs_cnt, 3 * NW);
    timing_checks("full");
    check("R11 supply after end", sup, 0);
    check("R11 ce_n after end", ce_n, 1);
    repeat (20) @(negedge clk);
    check("R11 pass held", pass_s, 1);

    // Cap boundary: exactly RETRY_MAX strobes still pass
    prep(1, 16'h1234);
    need[5] = RMAX;
    run(3, 6);
    check("R6 pass at cap", pass_s, 1);
    check("R6 strobes at cap word", pcount[5], RMAX);
    check("R6 strobes neighbour", pcount[6], 1);
    check("R10 source words subrange", hs_cnt, 12);
    timing_checks("cap");

    // One beyond the cap
    prep(1, 16'h00FF);
    need[5] = RMAX + 1;
    run(2, 9);
    check("R7 fail flag", fail_s, 1);
    check("R7 pass low", pass_s, 0);
    check("R7 fail address", fail_addr, 5);
    check("R7 fail strobes", fail_pulses, RMAX);
    check("R7 strobes applied", pcount[5], RMAX);
    for (int i = 6; i <= 9; i++) check($sformatf("R7 untouched word %0d", i), pcount[i], 0);
    check("R7 no check pass", reads_hi + reads_lo, 0);
    check("R11 supply after fail", sup, 0);

    // Weak at the lower check level
    prep(1, 16'hA5A5);
    weak_lo = 7;
    run(0, 9);
    check("R9 fail at lower level", fail_s, 1);
    check("R9 lower fail address", fail_addr, 7);
    check("R9 lower fail strobes", fail_pulses, 0);
    check("R8 upper reads before lower", reads_hi, 10);
    check("R9 lower reads until fail", reads_lo, 8);

    // Weak at the upper check level
    prep(1, 16'h0F0F);
    weak_hi = 4;
    run(0, 9);
    check("R9 fail at upper level", fail_s, 1);
    check("R9 upper fail address", fail_addr, 4);
    check("R9 upper reads until fail", reads_hi, 5);
    check("R9 no lower reads", reads_lo, 0);

    // Start while busy is ignored
    prep(2, 16'h7E7E);
    @(negedge clk);
    first_i = 4'd0; last_i = 4'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (60) @(negedge clk);
    first_i = 4'd8; last_i = 4'd15; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 pass despite mid-run start", pass_s, 1);
    check("R11 source words of first range", hs_cnt, 12);
    tot = 0;
    for (int i = 8; i < NW; i++) tot += pcount[i];
    check("R11 ignored range untouched", tot, 0);
    check("R6 strobes with need two", pcount[3], 2);
    timing_checks("busy");

    wd_done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule